// File: doc/BRIEF.md
# Shifter with carry out

This block is a purely combinational barrel shifter for the second operand of a processor datapath. It takes an operand, a 3-bit shift-kind code, an 8-bit shift amount and the incoming carry flag. It returns the shifted operand and the carry-out bit that a flag-setting ALU would store.

Five kinds of shift are supported: logical left, logical right, arithmetic right, rotate right, and rotate right by one through the carry. The carry-out is defined for every shift amount from 0 to 255. An amount of zero, an amount inside the operand width and an amount beyond the width each have their own rule.

All shifts share one right rotator, which is built either as a tree of log2(width) stages or from a shift operator. Thermometer masks then clear or sign-fill the vacated bit positions. The default width is 32. The width must be a power of two, and the amount field must be able to hold the width itself.

Top module: `shf_operand_unit`

## Requirements
- R1: With code 0 (logical left), 1 (logical right) or 2 (arithmetic right) and an amount of 0, the result equals the operand and the carry-out equals the carry-in.
- R2: With code 0 and an amount n from 1 to 32, the result is the operand shifted left by n with zeros filled in, and the carry-out is operand bit 32−n.
- R3: With code 0 and an amount above 32, the result is 0 and the carry-out is 0.
- R4: With code 1 and an amount n from 1 to 32, the result is the operand shifted right by n with zeros filled in, and the carry-out is operand bit n−1.
- R5: With code 1 and an amount above 32, the result is 0 and the carry-out is 0.
- R6: With code 2 and an amount n from 1 to 31, the result is the operand shifted right by n with copies of bit 31 filled in, and the carry-out is operand bit n−1.
- R7: With code 2 and an amount of exactly 32, every result bit equals operand bit 31, and the carry-out equals operand bit 31.
- R8: With code 2 and an amount above 32, the result is all ones with carry-out 1 when operand bit 31 is set, and is 0 with carry-out 0 otherwise.
- R9: With code 3 (rotate right) and an amount of 0, the result equals the operand and the carry-out equals the carry-in.
- R10: With code 3 and a nonzero amount n, the result is the operand rotated right by n modulo 32, and the carry-out equals result bit 31.
- R11: With code 4 (rotate right by one through carry), the result is the operand shifted right by one with the carry-in placed at bit 31, and the carry-out is operand bit 0. The amount is ignored.
- R12: With code 5, 6 or 7, the result equals the operand and the carry-out equals the carry-in, for any amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH (32) | Operand to shift |
| kind_i | input | 3 | Shift-kind code (0 to 4 defined; 5 to 7 pass the operand through) |
| amt_i | input | AMT_W (8) | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH (32) | Shifted operand |
| carry_o | output | 1 | Carry-out of the shift |

## Verification
The hardest cases to reach are where one amount range meets the next. These are an amount equal to the full width, the first amount beyond it, and rotate amounts that are exact multiples of the width. In each of these the rotator has wrapped to a rotation of zero, yet the result and carry must differ from a plain pass-through. The stimulus sweeps every amount from 0 to 255 for all eight codes. Each sweep uses operands with the sign bit both set and clear, single-bit walkers, alternating patterns and random words, and both values of the carry-in. Each result is compared with a model built from wide arithmetic shifts.

// File: rtl/shf_pkg.sv
package shf_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      SHK_LSL = 3'd0,
      SHK_LSR = 3'd1,
      SHK_ASR = 3'd2,
      SHK_ROR = 3'd3,
      SHK_RRX = 3'd4
   } shf_kind_e;

   typedef enum logic [1:0] {
      AMT_ZERO = 2'd0,
      AMT_MID  = 2'd1,
      AMT_OVER = 2'd2
   } shf_range_e;

endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8
) (
   input  logic [AMT_W-1:0]         amt_i,
   input  logic                     left_i,
   output shf_pkg::shf_range_e      range_o,
   output logic [$clog2(WIDTH)-1:0] rot_o
);
   import shf_pkg::*;

   localparam int LOG_W = $clog2(WIDTH);
   localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(WIDTH);

   logic [LOG_W-1:0] amt_lo;
   assign amt_lo = amt_i[LOG_W-1:0];

   always_comb begin
      if (amt_i == '0)
         range_o = AMT_ZERO;
      else if (amt_i > WIDTH_AMT)
         range_o = AMT_OVER;
      else
         range_o = AMT_MID;
   end

   // a left shift by n is a right rotation by (WIDTH - n) mod WIDTH
   assign rot_o = left_i ? (~amt_lo + LOG_W'(1)) : amt_lo;

endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
   parameter int WIDTH  = 32,
   parameter bit STAGED = 1'b1
) (
   input  logic [WIDTH-1:0]         data_i,
   input  logic [$clog2(WIDTH)-1:0] rot_i,
   output logic [WIDTH-1:0]         data_o
);
   localparam int LOG_W = $clog2(WIDTH);

   if (STAGED) begin : g_staged
      logic [WIDTH-1:0] stg [0:LOG_W];
      assign stg[0] = data_i;
      for (genvar k = 0; k < LOG_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = rot_i[k] ? {stg[k][SH-1:0], stg[k][WIDTH-1:SH]}
                                    : stg[k];
      end
      assign data_o = stg[LOG_W];
   end else begin : g_operator
      assign data_o = (data_i >> rot_i) | (data_i << (WIDTH - int'(rot_i)));
   end

endmodule

// File: rtl/shf_thermo.sv
module shf_thermo #(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8
) (
   input  logic [AMT_W-1:0] amt_i,
   output logic [WIDTH-1:0] low_o,
   output logic [WIDTH-1:0] high_o
);
   // low_o has its n lowest bits set, high_o its n highest bits
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign low_o[i]           = (amt_i > AMT_W'(i));
      assign high_o[WIDTH-1-i]  = low_o[i];
   end

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit #(
   parameter int WIDTH      = 32,
   parameter int AMT_W      = 8,
   parameter bit STAGED_ROT = 1'b1
) (
   input  logic [WIDTH-1:0]           opnd_i,
   input  logic [shf_pkg::KIND_W-1:0] kind_i,
   input  logic [AMT_W-1:0]           amt_i,
   input  logic                       carry_i,
   output logic [WIDTH-1:0]           result_o,
   output logic                       carry_o
);
   import shf_pkg::*;

   localparam int LOG_W = $clog2(WIDTH);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("shf_operand_unit: WIDTH must be a power of two of at least 2");
   end
   if (AMT_W < LOG_W + 1) begin : g_bad_amt
      $error("shf_operand_unit: AMT_W must be able to hold WIDTH");
   end

   shf_range_e       range;
   logic [LOG_W-1:0] rot;
   logic [WIDTH-1:0] rotated;
   logic [WIDTH-1:0] low_m;
   logic [WIDTH-1:0] high_m;
   logic             sign;

   assign sign = opnd_i[WIDTH-1];

   shf_amt_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
      .amt_i   (amt_i),
      .left_i  (kind_i == SHK_LSL),
      .range_o (range),
      .rot_o   (rot)
   );

   shf_rotator #(.WIDTH(WIDTH), .STAGED(STAGED_ROT)) u_rot (
      .data_i (opnd_i),
      .rot_i  (rot),
      .data_o (rotated)
   );

   shf_thermo #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_therm (
      .amt_i  (amt_i),
      .low_o  (low_m),
      .high_o (high_m)
   );

   always_comb begin
      result_o = opnd_i;
      carry_o  = carry_i;
      case (kind_i)
         SHK_LSL: begin
            if (range == AMT_MID) begin
               result_o = rotated & ~low_m;
               carry_o  = rotated[0];
            end else if (range == AMT_OVER) begin
               result_o = '0;
               carry_o  = 1'b0;
            end
         end
         SHK_LSR: begin
            if (range == AMT_MID) begin
               result_o = rotated & ~high_m;
               carry_o  = rotated[WIDTH-1];
            end else if (range == AMT_OVER) begin
               result_o = '0;
               carry_o  = 1'b0;
            end
         end
         SHK_ASR: begin
            if (range == AMT_MID) begin
               result_o = (rotated & ~high_m) | ({WIDTH{sign}} & high_m);
               carry_o  = rotated[WIDTH-1];
            end else if (range == AMT_OVER) begin
               result_o = {WIDTH{sign}};
               carry_o  = sign;
            end
         end
         SHK_ROR: begin
            if (range != AMT_ZERO) begin
               result_o = rotated;
               carry_o  = rotated[WIDTH-1];
            end
         end
         SHK_RRX: begin
            result_o = {carry_i, opnd_i[WIDTH-1:1]};
            carry_o  = opnd_i[0];
         end
         default: begin
            result_o = opnd_i;
            carry_o  = carry_i;
         end
      endcase
   end

endmodule

// File: rtl/shf_operand_unit_chk.sv
module shf_operand_unit_chk #(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8
) (
   input logic [WIDTH-1:0]           opnd_i,
   input logic [shf_pkg::KIND_W-1:0] kind_i,
   input logic [AMT_W-1:0]           amt_i,
   input logic                       carry_i,
   input logic [WIDTH-1:0]           result_o,
   input logic                       carry_o
);
   import shf_pkg::*;

   int n;
   assign n = int'(amt_i);

   always_comb begin
      if (!$isunknown({opnd_i, kind_i, amt_i, carry_i, result_o, carry_o})) begin
         if (kind_i <= SHK_ASR && n == 0)
            a_r1_zero_pass: assert (result_o == opnd_i && carry_o == carry_i);
         if (kind_i == SHK_LSL && n >= 1 && n <= WIDTH)
            a_r2_lsl_carry: assert (carry_o == opnd_i[WIDTH-n]);
         if (kind_i == SHK_LSL && n > WIDTH)
            a_r3_lsl_over: assert (result_o == '0 && !carry_o);
         if (kind_i == SHK_LSR && n >= 1 && n <= WIDTH)
            a_r4_lsr_carry: assert (carry_o == opnd_i[n-1]);
         if (kind_i == SHK_LSR && n > WIDTH)
            a_r5_lsr_over: assert (result_o == '0 && !carry_o);
         if (kind_i == SHK_ASR && n >= 1 && n < WIDTH)
            a_r6_asr_sign: assert (result_o[WIDTH-1] == opnd_i[WIDTH-1] && carry_o == opnd_i[n-1]);
         if (kind_i == SHK_ASR && n == WIDTH)
            a_r7_asr_full: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1]);
         if (kind_i == SHK_ASR && n > WIDTH)
            a_r8_asr_over: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1]);
         if (kind_i == SHK_ROR && n == 0)
            a_r9_ror_zero: assert (result_o == opnd_i && carry_o == carry_i);
         if (kind_i == SHK_ROR && n != 0)
            a_r10_ror_carry: assert (carry_o == result_o[WIDTH-1] && $countones(result_o) == $countones(opnd_i));
         if (kind_i == SHK_RRX)
            a_r11_rrx: assert (result_o[WIDTH-1] == carry_i && carry_o == opnd_i[0]);
         if (kind_i > SHK_RRX)
            a_r12_pass: assert (result_o == opnd_i && carry_o == carry_i);
      end
   end

endmodule

bind shf_operand_unit shf_operand_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) chk_i (
   .opnd_i   (opnd_i),
   .kind_i   (kind_i),
   .amt_i    (amt_i),
   .carry_i  (carry_i),
   .result_o (result_o),
   .carry_o  (carry_o)
);

// File: tb/shf_operand_unit_tb_top.sv
`timescale 1ns/1ps
module shf_operand_unit_tb_top;

   localparam real CLK_HALF = 2.0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opnd;
   logic [2:0]  kind;
   logic [7:0]  amt;
   logic        cin;
   logic [31:0] res;
   logic        cout;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   shf_operand_unit dut_i (
      .opnd_i   (opnd),
      .kind_i   (kind),
      .amt_i    (amt),
      .carry_i  (cin),
      .result_o (res),
      .carry_o  (cout)
   );

   function automatic string req_tag(input logic [2:0] k, input int n);
      case (k)
         3'd0: return (n == 0) ? "R1" : (n <= 32) ? "R2" : "R3";
         3'd1: return (n == 0) ? "R1" : (n <= 32) ? "R4" : "R5";
         3'd2: return (n == 0) ? "R1" : (n < 32) ? "R6" : (n == 32) ? "R7" : "R8";
         3'd3: return (n == 0) ? "R9" : "R10";
         3'd4: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic model(input logic [31:0] op, input logic [2:0] k, input int n,
                        input logic c, output logic [31:0] er, output logic ec);
      logic [63:0] wide;
      logic [64:0] sx;
      er = op;
      ec = c;
      case (k)
         3'd0: if (n != 0) begin
            if (n <= 32) begin
               wide = {32'd0, op} << n;
               er = wide[31:0];
               ec = wide[32];
            end else begin
               er = '0; ec = 1'b0;
            end
         end
         3'd1: if (n != 0) begin
            if (n <= 32) begin
               wide = {op, 32'd0} >> n;
               er = wide[63:32];
               ec = wide[31];
            end else begin
               er = '0; ec = 1'b0;
            end
         end
         3'd2: if (n != 0) begin
            sx = $signed({{32{op[31]}}, op, 1'b0}) >>> n;
            er = sx[32:1];
            ec = sx[0];
         end
         3'd3: if (n != 0) begin
            wide = {op, op} >> (n % 32);
            er = wide[31:0];
            ec = er[31];
         end
         3'd4: begin
            er = {c, op[31:1]};
            ec = op[0];
         end
         default: ;
      endcase
   endtask

   task automatic apply(input logic [31:0] op, input logic [2:0] k, input int n,
                        input logic c);
      logic [31:0] er;
      logic        ec;
      @(negedge clk);
      opnd = op; kind = k; amt = 8'(n); cin = c;
      model(op, k, n, c, er, ec);
      #1;
      total++;
      if (res !== er || cout !== ec) begin
         bad++;
         $display("FAIL %s code=%0d amt=%0d op=%h cin=%b: got res=%h c=%b expected res=%h c=%b",
                  req_tag(k, n), k, n, op, c, res, cout, er, ec);
      end
   endtask

   initial begin
      logic [31:0] pats [0:5];
      opnd = '0; kind = '0; amt = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // quiet state: all-zero inputs give a zero result and zero carry (R1)
      @(negedge clk);
      #1;
      total++;
      if (res !== 32'd0 || cout !== 1'b0) begin
         bad++;
         $display("FAIL R1 idle: got res=%h c=%b expected res=00000000 c=0", res, cout);
      end
      for (int k = 0; k < 8; k++) begin
         for (int n = 0; n < 256; n++) begin
            pats[0] = 32'h8000_0001;
            pats[1] = 32'h7FFF_FFFE;
            pats[2] = 32'hA5A5_5A5A;
            pats[3] = 32'd1 << (n % 32);
            pats[4] = $urandom | 32'h8000_0000;
            pats[5] = $urandom & 32'h7FFF_FFFF;
            for (int p = 0; p < 6; p++)
               apply(pats[p], 3'(k), n, 1'((p + n) & 1));
         end
      end
      // targeted edges: exact width, first beyond, rotate multiples
      apply(32'h8000_0000, 3'd2, 32, 1'b0);   // R7
      apply(32'h4000_0000, 3'd2, 33, 1'b1);   // R8
      apply(32'h0000_0001, 3'd0, 32, 1'b0);   // R2
      apply(32'h8000_0000, 3'd1, 32, 1'b0);   // R4
      apply(32'h8000_0000, 3'd3, 64, 1'b0);   // R10
      apply(32'h0000_0001, 3'd4, 200, 1'b1);  // R11
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4.0 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule